// File: doc/BRIEF.md
# ATM Transmit Cell Buffer with Fill-Cell Insertion

This block sits between a cell source and a transmit framer. The source writes 53-byte ATM cells one byte per cycle, marking the first byte of each cell. The block keeps whole cells in an internal FIFO of cell slots. When the framer signals the start of a cell-insertion slot, the block plays out exactly 53 bytes on consecutive cycles: the oldest complete stored cell if there is one, otherwise a fill cell. A configuration input chooses the fill type, idle or unassigned.

While writing, the block can compute the header error check and put it in the fifth header byte, replacing whatever the source supplied there. A second configuration input turns this off so that the source's fifth byte is stored unchanged. A cell that is only partly written is never eligible for output. A new start-of-cell marker in the middle of a cell abandons the partial cell.

Top module: `atm_tx_cell_buf`

## Requirements
- R1: After reset, `rd_valid_o`, `rd_soc_o` and `full_o` are 0 and the buffer holds no cells.
- R2: A cell becomes eligible for output only after its 53rd byte has been written. A slot request made while only part of a cell is stored produces a fill cell.
- R3: A slot request taken while no cell is being played out starts output in the next cycle. `rd_valid_o` is then 1 for exactly 53 consecutive cycles, and `rd_soc_o` is 1 on the first of them only. Slot requests made during playout are ignored.
- R4: With `cfg_fill_unassigned_i`=0 at the request, the fill cell is header 00 00 00 01 52 (hex) followed by 48 payload bytes of 6A.
- R5: With `cfg_fill_unassigned_i`=1 at the request, the fill cell is header 00 00 00 00 55 (hex) followed by 48 payload bytes of 6A.
- R6: With `cfg_hec_bypass_i`=0, the fifth byte written is discarded. It is replaced by the CRC-8 (generator x^8+x^2+x+1, initial value 0, MSB first) of header bytes 1 to 4, XORed with 55 hex.
- R7: With `cfg_hec_bypass_i`=1, the fifth byte is stored and sent exactly as written.
- R8: A write with `wr_soc_i`=1 while a cell is partly written discards the partial cell, and that byte becomes byte 1 of a new cell.
- R9: The buffer holds 4 cells. `full_o` is 1 while 4 complete cells are stored, and writes offered while `full_o`=1 are dropped.
- R10: Stored cells are sent in the order they were completed, with all 53 bytes unchanged apart from R6.
- R11: A cell whose last byte is written in the same cycle that a slot request is taken is not eligible for that slot. A fill cell is sent, and the new cell is sent in the following slot.
- R12: Bytes written with `wr_soc_i`=0 while no cell is in progress are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_data_i | input | 8 | Write byte |
| wr_valid_i | input | 1 | Write byte valid |
| wr_soc_i | input | 1 | Write byte is first of a cell |
| full_o | output | 1 | All cell slots hold complete cells |
| slot_req_i | input | 1 | Start of a cell-insertion slot |
| rd_data_o | output | 8 | Output byte |
| rd_valid_o | output | 1 | Output byte valid |
| rd_soc_o | output | 1 | Output byte is first of a cell |
| cfg_fill_unassigned_i | input | 1 | 1: unassigned fill, 0: idle fill |
| cfg_hec_bypass_i | input | 1 | 1: keep written fifth byte, 0: compute HEC |

## Verification
The completion of a cell by its 53rd write and the acceptance of a slot request can occur on the same clock edge. In that case the eligibility decision must use the cell count from before the commit. The bench provokes this by writing 52 bytes and then driving the final byte and the slot request together in one cycle. It expects an idle fill cell in that slot and the freshly completed cell, with its computed HEC, in the next requested slot.

// File: rtl/atm_txbuf_pkg.sv
package atm_txbuf_pkg;
  localparam int CELL_BYTES = 53;
  localparam int HEC_IDX    = 4;
  localparam logic [7:0] HEC_COSET    = 8'h55;
  localparam logic [7:0] FILL_PAYLOAD = 8'h6A;

  // one byte of CRC-8, generator x^8+x^2+x+1, MSB first
  function automatic logic [7:0] crc8_step(input logic [7:0] crc, input logic [7:0] d);
    logic [7:0] c;
    c = crc ^ d;
    for (int b = 0; b < 8; b++) begin
      c = c[7] ? ((c << 1) ^ 8'h07) : (c << 1);
    end
    return c;
  endfunction

  function automatic logic [7:0] fill_byte(input logic unassigned, input logic [5:0] idx);
    logic [7:0] v;
    if (idx < 6'd3)        v = 8'h00;
    else if (idx == 6'd3)  v = unassigned ? 8'h00 : 8'h01;
    else if (idx == 6'd4)  v = unassigned ? 8'h55 : 8'h52;
    else                   v = FILL_PAYLOAD;
    return v;
  endfunction
endpackage

// File: rtl/atm_txbuf_mem.sv
module atm_txbuf_mem #(
  parameter int DEPTH = 212,
  parameter int AW    = 8
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [7:0]    rdata_o
);
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/atm_txbuf_wr.sv
module atm_txbuf_wr
  import atm_txbuf_pkg::*;
#(
  parameter int CELLS = 4,
  parameter int AW    = 8,
  parameter int PW    = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [7:0]    wr_data_i,
  input  logic          wr_valid_i,
  input  logic          wr_soc_i,
  input  logic          full_i,
  input  logic          hec_bypass_i,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [7:0]    mem_data_o,
  output logic          commit_o
);
  localparam logic [5:0]    LAST_OFF = 6'(CELL_BYTES - 1);
  localparam logic [PW-1:0] LAST_SLOT = PW'(CELLS - 1);

  logic          in_cell_q;
  logic [5:0]    off_q;
  logic [7:0]    crc_q;
  logic [PW-1:0] slot_q;
  logic          accept;
  logic          start;
  logic          cont;
  logic [5:0]    off_use;

  assign accept = wr_valid_i && !full_i;
  assign start  = accept && wr_soc_i;
  assign cont   = accept && !wr_soc_i && in_cell_q;

  always_comb begin
    off_use    = start ? 6'd0 : off_q;
    mem_we_o   = start || cont;
    mem_data_o = wr_data_i;
    if (cont && off_q == 6'(HEC_IDX) && !hec_bypass_i) mem_data_o = crc_q ^ HEC_COSET;
    mem_addr_o = AW'(slot_q) * AW'(CELL_BYTES) + AW'(off_use);
  end

  assign commit_o = cont && off_q == LAST_OFF;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_cell_q <= 1'b0;
      off_q     <= '0;
      crc_q     <= '0;
      slot_q    <= '0;
    end else if (start) begin
      // restart at the same slot; any partial cell is dropped
      in_cell_q <= 1'b1;
      off_q     <= 6'd1;
      crc_q     <= crc8_step(8'h00, wr_data_i);
    end else if (cont) begin
      if (off_q < 6'(HEC_IDX)) crc_q <= crc8_step(crc_q, wr_data_i);
      if (off_q == LAST_OFF) begin
        in_cell_q <= 1'b0;
        off_q     <= '0;
        slot_q    <= (slot_q == LAST_SLOT) ? '0 : slot_q + 1'b1;
      end else begin
        off_q <= off_q + 6'd1;
      end
    end
  end
endmodule

// File: rtl/atm_txbuf_rd.sv
module atm_txbuf_rd
  import atm_txbuf_pkg::*;
#(
  parameter int CELLS = 4,
  parameter int AW    = 8,
  parameter int PW    = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          slot_req_i,
  input  logic          cell_avail_i,
  input  logic          fill_unassigned_i,
  output logic [AW-1:0] mem_addr_o,
  input  logic [7:0]    mem_data_i,
  output logic [7:0]    rd_data_o,
  output logic          rd_valid_o,
  output logic          rd_soc_o,
  output logic          release_o
);
  localparam logic [5:0]    LAST_IDX  = 6'(CELL_BYTES - 1);
  localparam logic [PW-1:0] LAST_SLOT = PW'(CELLS - 1);

  logic          busy_q;
  logic [5:0]    idx_q;
  logic          fill_q;
  logic          unassigned_q;
  logic [PW-1:0] slot_q;
  logic          last;

  assign last       = busy_q && idx_q == LAST_IDX;
  assign release_o  = last && !fill_q;
  assign mem_addr_o = AW'(slot_q) * AW'(CELL_BYTES) + AW'(idx_q);
  assign rd_valid_o = busy_q;
  assign rd_soc_o   = busy_q && idx_q == 6'd0;
  assign rd_data_o  = !busy_q ? 8'h00 :
                      fill_q  ? fill_byte(unassigned_q, idx_q) : mem_data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q       <= 1'b0;
      idx_q        <= '0;
      fill_q       <= 1'b0;
      unassigned_q <= 1'b0;
      slot_q       <= '0;
    end else if (!busy_q) begin
      if (slot_req_i) begin
        busy_q       <= 1'b1;
        idx_q        <= '0;
        fill_q       <= !cell_avail_i;
        unassigned_q <= fill_unassigned_i;
      end
    end else if (last) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      if (!fill_q) slot_q <= (slot_q == LAST_SLOT) ? '0 : slot_q + 1'b1;
    end else begin
      idx_q <= idx_q + 6'd1;
    end
  end

  assert_cell_contiguous_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && idx_q != LAST_IDX) |=> (busy_q && idx_q == $past(idx_q) + 6'd1));

  assert_single_soc_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_soc_o |=> !rd_soc_o);
endmodule

// File: rtl/atm_tx_cell_buf.sv
module atm_tx_cell_buf
  import atm_txbuf_pkg::*;
#(
  parameter int CELLS = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [7:0] wr_data_i,
  input  logic       wr_valid_i,
  input  logic       wr_soc_i,
  output logic       full_o,
  input  logic       slot_req_i,
  output logic [7:0] rd_data_o,
  output logic       rd_valid_o,
  output logic       rd_soc_o,
  input  logic       cfg_fill_unassigned_i,
  input  logic       cfg_hec_bypass_i
);
  localparam int DEPTH = CELLS * CELL_BYTES;
  localparam int AW    = $clog2(DEPTH);
  localparam int PW    = (CELLS > 1) ? $clog2(CELLS) : 1;
  localparam int CW    = $clog2(CELLS + 1);

  logic [CW-1:0] count_q;
  logic          mem_we;
  logic [AW-1:0] waddr, raddr;
  logic [7:0]    wdata, rdata;
  logic          commit, release_c;

  assign full_o = count_q == CW'(CELLS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) count_q <= '0;
    else if (commit && !release_c) count_q <= count_q + 1'b1;
    else if (!commit && release_c) count_q <= count_q - 1'b1;
  end

  atm_txbuf_wr #(.CELLS(CELLS), .AW(AW), .PW(PW)) u_wr (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_data_i    (wr_data_i),
    .wr_valid_i   (wr_valid_i),
    .wr_soc_i     (wr_soc_i),
    .full_i       (full_o),
    .hec_bypass_i (cfg_hec_bypass_i),
    .mem_we_o     (mem_we),
    .mem_addr_o   (waddr),
    .mem_data_o   (wdata),
    .commit_o     (commit)
  );

  atm_txbuf_mem #(.DEPTH(DEPTH), .AW(AW)) u_mem (
    .clk_i   (clk_i),
    .we_i    (mem_we),
    .waddr_i (waddr),
    .wdata_i (wdata),
    .raddr_i (raddr),
    .rdata_o (rdata)
  );

  atm_txbuf_rd #(.CELLS(CELLS), .AW(AW), .PW(PW)) u_rd (
    .clk_i             (clk_i),
    .rst_ni            (rst_ni),
    .slot_req_i        (slot_req_i),
    .cell_avail_i      (count_q != '0),
    .fill_unassigned_i (cfg_fill_unassigned_i),
    .mem_addr_o        (raddr),
    .mem_data_i        (rdata),
    .rd_data_o         (rd_data_o),
    .rd_valid_o        (rd_valid_o),
    .rd_soc_o          (rd_soc_o),
    .release_o         (release_c)
  );

  assert_count_bound_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CW'(CELLS));

  assert_no_write_when_full_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> !mem_we);

  assert_release_nonempty_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    release_c |-> count_q != '0);
endmodule

// File: tb/atm_tx_cell_buf_tb.sv
module atm_tx_cell_buf_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] wr_data = '0;
  logic       wr_valid = 1'b0, wr_soc = 1'b0, slot_req = 1'b0;
  logic       cfg_unas = 1'b0, cfg_byp = 1'b0;
  logic       full, rd_valid, rd_soc;
  logic [7:0] rd_data;
  logic [7:0] got [53];
  int n_checks = 0, n_fail = 0;

  always #5 clk = ~clk;

  atm_tx_cell_buf u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_data_i(wr_data), .wr_valid_i(wr_valid),
    .wr_soc_i(wr_soc), .full_o(full), .slot_req_i(slot_req), .rd_data_o(rd_data),
    .rd_valid_o(rd_valid), .rd_soc_o(rd_soc), .cfg_fill_unassigned_i(cfg_unas),
    .cfg_hec_bypass_i(cfg_byp)
  );

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // bitwise model of the header check, 32 header bits through an 8-bit LFSR
  function automatic logic [7:0] ref_hec(input logic [31:0] h);
    logic [7:0] r = 8'h00;
    for (int i = 31; i >= 0; i--) begin
      logic fb = r[7] ^ h[i];
      r = {r[6:0], 1'b0};
      if (fb) r = r ^ 8'h07;
    end
    return r ^ 8'h55;
  endfunction

  function automatic logic [7:0] src_byte(input logic [7:0] tag, input int i);
    return (i == 4) ? 8'hEE : tag + 8'(i);
  endfunction

  function automatic logic [7:0] exp_byte(input logic [7:0] tag, input int i, input logic hec_on);
    if (i == 4) return hec_on ? ref_hec({tag, tag + 8'd1, tag + 8'd2, tag + 8'd3}) : 8'hEE;
    return src_byte(tag, i);
  endfunction

  task automatic send_bytes(input logic [7:0] tag, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wr_valid = 1'b1; wr_soc = (i == 0); wr_data = src_byte(tag, i);
    end
    @(negedge clk);
    wr_valid = 1'b0; wr_soc = 1'b0;
  endtask

  // output starts in the cycle after the request edge
  task automatic collect(input string req, input int poke_at);
    for (int i = 0; i < 53; i++) begin
      if (!rd_valid || rd_soc != (i == 0)) begin
        check(1'b0, req, {rd_valid, rd_soc}, {1'b1, i == 0});
      end
      got[i] = rd_data;
      slot_req = (i == poke_at);
      @(negedge clk);
    end
    slot_req = 1'b0;
    check(!rd_valid, "R3 playout length 53", rd_valid, 0);
    @(negedge clk);
    check(!rd_valid, "R3 no restart from request during playout", rd_valid, 0);
  endtask

  task automatic request(input string req, input int poke_at);
    @(negedge clk); slot_req = 1'b1;
    @(negedge clk); slot_req = 1'b0;
    collect(req, poke_at);
  endtask

  task automatic expect_cell(input logic [7:0] tag, input logic hec_on, input string req);
    int bad = -1;
    for (int i = 52; i >= 0; i--) if (got[i] !== exp_byte(tag, i, hec_on)) bad = i;
    if (bad < 0) check(1'b1, req, 0, 0);
    else check(1'b0, req, got[bad], exp_byte(tag, bad, hec_on));
  endtask

  task automatic expect_fill(input logic unas, input string req);
    int bad = -1;
    logic [7:0] e [53];
    for (int i = 0; i < 53; i++) e[i] = 8'h6A;
    e[0] = 0; e[1] = 0; e[2] = 0; e[3] = unas ? 8'h00 : 8'h01; e[4] = unas ? 8'h55 : 8'h52;
    for (int i = 52; i >= 0; i--) if (got[i] !== e[i]) bad = i;
    if (bad < 0) check(1'b1, req, 0, 0);
    else check(1'b0, req, got[bad], e[bad]);
  endtask

  task automatic t_reset;
    check(!rd_valid && !rd_soc && !full, "R1 reset outputs", {rd_valid, rd_soc, full}, 0);
    request("R1 empty after reset", -1);
    expect_fill(1'b0, "R1 first slot is fill");
  endtask

  task automatic t_fill_types;
    request("R4 idle playout", -1);
    expect_fill(1'b0, "R4 idle fill bytes");
    cfg_unas = 1'b1;
    request("R5 unassigned playout", -1);
    expect_fill(1'b1, "R5 unassigned fill bytes");
    cfg_unas = 1'b0;
  endtask

  task automatic t_hec;
    send_bytes(8'h10, 53);
    request("R6 playout", -1);
    expect_cell(8'h10, 1'b1, "R6 computed HEC in fifth byte");
    send_bytes(8'hC0, 53);
    request("R6 playout 2", -1);
    expect_cell(8'hC0, 1'b1, "R6 computed HEC, high-bit header");
    cfg_byp = 1'b1;
    send_bytes(8'h40, 53);
    cfg_byp = 1'b0;
    request("R7 playout", -1);
    expect_cell(8'h40, 1'b0, "R7 fifth byte passed through");
  endtask

  task automatic t_partial;
    send_bytes(8'h50, 30);
    request("R2 playout", -1);
    expect_fill(1'b0, "R2 partial cell not sent");
    send_bytes(8'h60, 53);
    request("R8 playout", -1);
    expect_cell(8'h60, 1'b1, "R8 restart on mid-cell start marker");
    request("R8 playout 2", -1);
    expect_fill(1'b0, "R8 partial cell discarded");
  endtask

  task automatic t_stray;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); wr_valid = 1'b1; wr_soc = 1'b0; wr_data = 8'(i);
    end
    @(negedge clk); wr_valid = 1'b0;
    request("R12 playout", -1);
    expect_fill(1'b0, "R12 bytes outside a cell dropped");
    send_bytes(8'h70, 53);
    request("R12 playout 2", -1);
    expect_cell(8'h70, 1'b1, "R12 next cell intact");
  endtask

  task automatic t_full;
    send_bytes(8'h80, 53);
    send_bytes(8'h90, 53);
    send_bytes(8'hA0, 53);
    check(!full, "R9 not full at 3 cells", full, 0);
    send_bytes(8'hB0, 53);
    check(full, "R9 full at 4 cells", full, 1);
    send_bytes(8'h20, 53);
    request("R10 playout", 10);
    expect_cell(8'h80, 1'b1, "R10 order 1");
    check(!full, "R9 full clears after playout", full, 0);
    request("R10 playout", -1); expect_cell(8'h90, 1'b1, "R10 order 2");
    request("R10 playout", -1); expect_cell(8'hA0, 1'b1, "R10 order 3");
    request("R10 playout", -1); expect_cell(8'hB0, 1'b1, "R10 order 4");
    request("R9 playout", -1);
    expect_fill(1'b0, "R9 write while full dropped");
  endtask

  task automatic t_same_cycle;
    for (int i = 0; i < 52; i++) begin
      @(negedge clk); wr_valid = 1'b1; wr_soc = (i == 0); wr_data = src_byte(8'h30, i);
    end
    @(negedge clk);
    wr_data = src_byte(8'h30, 52); wr_soc = 1'b0; slot_req = 1'b1;
    @(negedge clk);
    wr_valid = 1'b0; slot_req = 1'b0;
    collect("R11 playout", -1);
    expect_fill(1'b0, "R11 cell completing at request edge not sent");
    request("R11 playout 2", -1);
    expect_cell(8'h30, 1'b1, "R11 cell sent in following slot");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fill_types();
    t_hec();
    t_partial();
    t_stray();
    t_full();
    t_same_cycle();
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule